// File: doc/BRIEF.md
# Multicycle 32-bit RISC Core

This block is a small 32-bit integer processor. It runs each instruction as a sequence of clock cycles. One ALU and one unified memory port are shared between those cycles. Five internal holding registers carry values from one cycle to the next: the instruction word, the memory read data, the two source operands and the ALU result. None of them is visible to the program. A Moore controller with a 4-bit state register selects the ALU operands, the memory address source, the next-PC source and every write enable. Those controls depend only on the state.

Every instruction starts with a fetch step and a decode step. The fetch step loads the instruction word and advances the PC by four. The decode step reads both source registers and computes a speculative branch target. After that, each instruction class takes its own path. Branches and jumps finish in three cycles. Register-register ALU operations, add-immediate and stores finish in four. Loads finish in five.

Program and data share a word array inside the block. The surrounding environment fills the array through a write port while the core is held in reset. A combinational read port lets it inspect any word. A one-cycle retire pulse marks the last cycle of each instruction.

Top module: `mc_core`

## Requirements
- R1: While reset is applied, and in the first cycle after the synchronised reset release, `pc` reads 0 and `retire` is low. Execution starts by fetching word 0.
- R2: In a fetch cycle the instruction register captures the memory word at the PC, and the PC becomes PC+4 at the same clock edge.
- R3: Opcode 0 is a register-register operation on rs = bits 25:21 and rt = bits 20:16, with the result written to rd = bits 15:11. Bits 5:0 select the operation: 32 add, 34 subtract, 36 AND, 37 OR, 42 signed set-on-less-than (result 1 or 0). The instruction takes 4 cycles.
- R4: Opcode 8 writes rs plus the sign-extended bits 15:0 into rt, in 4 cycles.
- R5: Opcode 35 loads into rt the memory word at byte address rs + sign-extended offset. The word index is taken from byte address bits 9:2. The load takes 5 cycles.
- R6: Opcode 43 stores rt to the memory word at rs + sign-extended offset, in 4 cycles.
- R7: Opcode 4 compares rs and rt. When they are equal the next PC is PC+4 plus the sign-extended offset shifted left by two. Otherwise the next PC is PC+4. The instruction takes 3 cycles.
- R8: Opcode 2 sets the PC to the top four bits of PC+4, followed by bits 25:0, followed by two zero bits, in 3 cycles.
- R9: Register 0 always reads as zero. Writes to it are discarded.
- R10: `retire` is high for exactly one cycle per completed instruction, in its final cycle. The next cycle is a fetch.
- R11: An opcode outside the set above uses only the fetch and decode cycles. It changes nothing except PC+4 and does not pulse `retire`.
- R12: `load_we` writes `load_data` into word `load_addr` at the clock edge. `peek_data` shows word `peek_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_we | input | 1 | Write strobe for the memory fill port |
| load_addr | input | MAW | Word index for the fill port |
| load_data | input | 32 | Word to write through the fill port |
| peek_addr | input | MAW | Word index for the inspection port |
| peek_data | output | 32 | Memory word at `peek_addr` |
| retire | output | 1 | High in the last cycle of each instruction |
| pc | output | 32 | Current program counter |

## Verification
The bench counts cycles from reset release and samples on the falling edge. The retire pulse of each instruction has to appear on the 3rd, 4th or 5th sampled cycle after the previous one, depending on class, plus two cycles for every illegal word skipped on the way. The bench checks the PC one sample after each retire. For ALU instructions the PC moved during fetch; a branch or jump writes it at the retiring edge, so the new value is visible one cycle after the pulse. Register results are checked through stores. Once the reference model reaches the halt loop, the whole data region is compared through the combinational inspection port, where each read is valid in the same cycle it is requested.

// File: rtl/mc_pkg.sv
package mc_pkg;

  localparam int XLEN = 32;
  localparam int RAW  = 5;

  typedef enum logic [3:0] {
    S_FETCH  = 4'd0,
    S_DECODE = 4'd1,
    S_MEMADR = 4'd2,
    S_MEMRD  = 4'd3,
    S_LDWB   = 4'd4,
    S_MEMWR  = 4'd5,
    S_REXEC  = 4'd6,
    S_RWB    = 4'd7,
    S_BRANCH = 4'd8,
    S_JUMP   = 4'd9,
    S_IEXEC  = 4'd10,
    S_IWB    = 4'd11
  } state_t;

  localparam logic [5:0] OP_REG  = 6'd0;
  localparam logic [5:0] OP_JMP  = 6'd2;
  localparam logic [5:0] OP_BEQ  = 6'd4;
  localparam logic [5:0] OP_ADDI = 6'd8;
  localparam logic [5:0] OP_LW   = 6'd35;
  localparam logic [5:0] OP_SW   = 6'd43;

  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_AND = 6'd36;
  localparam logic [5:0] FN_OR  = 6'd37;
  localparam logic [5:0] FN_SLT = 6'd42;

  typedef enum logic [2:0] {
    ALU_AND, ALU_OR, ALU_ADD, ALU_SUB, ALU_SLT
  } alu_fn_t;

  typedef enum logic [1:0] {
    MODE_ADD, MODE_SUB, MODE_FUNCT
  } alu_mode_t;

  typedef enum logic [1:0] {
    SB_REG, SB_FOUR, SB_IMM, SB_BROFF
  } srcb_t;

  typedef enum logic [1:0] {
    PCN_ALU, PCN_ALUOUT, PCN_JUMP
  } pcsel_t;

  typedef struct packed {
    logic      ir_we;
    logic      pc_we;
    logic      pc_cond;
    pcsel_t    pc_sel;
    logic      addr_aluout;
    logic      mem_we;
    logic      mdr_we;
    logic      rf_we;
    logic      dst_rd;
    logic      wb_mdr;
    logic      srca_reg;
    srcb_t     srcb;
    alu_mode_t alu_mode;
    logic      retire;
  } ctrl_t;

  function automatic alu_fn_t alu_select(alu_mode_t mode, logic [5:0] funct);
    alu_fn_t f;
    case (mode)
      MODE_ADD: f = ALU_ADD;
      MODE_SUB: f = ALU_SUB;
      default: begin
        case (funct)
          FN_SUB:  f = ALU_SUB;
          FN_AND:  f = ALU_AND;
          FN_OR:   f = ALU_OR;
          FN_SLT:  f = ALU_SLT;
          default: f = ALU_ADD;
        endcase
      end
    endcase
    return f;
  endfunction

endpackage

// File: rtl/mc_rst_sync.sv
module mc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/mc_regfile.sv
module mc_regfile import mc_pkg::*; #(
  parameter int NREGS = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RAW-1:0]  ra1,
  input  logic [RAW-1:0]  ra2,
  output logic [XLEN-1:0] rd1,
  output logic [XLEN-1:0] rd2,
  input  logic            we,
  input  logic [RAW-1:0]  wa,
  input  logic [XLEN-1:0] wd
);

  logic [XLEN-1:0] regs [NREGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (we && (wa != '0)) begin
      regs[wa] <= wd;
    end
  end

  assign rd1 = regs[ra1];
  assign rd2 = regs[ra2];

  // R9: the zero register never holds anything but zero
  assert_zero_reg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    regs[0] == '0);

endmodule

// File: rtl/mc_alu.sv
module mc_alu import mc_pkg::*; (
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  alu_fn_t         fn,
  output logic [XLEN-1:0] y,
  output logic            zero
);

  logic [XLEN-1:0] diff;
  assign diff = opa - opb;

  always_comb begin
    case (fn)
      ALU_AND: y = opa & opb;
      ALU_OR:  y = opa | opb;
      ALU_SUB: y = diff;
      ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(opa) < $signed(opb))};
      default: y = opa + opb;
    endcase
  end

  assign zero = (diff == '0);

endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl import mc_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] opcode,
  output state_t     state,
  output ctrl_t      ctl
);

  state_t state_q, state_d;

  always_comb begin
    state_d = S_FETCH;
    case (state_q)
      S_FETCH:  state_d = S_DECODE;
      S_DECODE: begin
        case (opcode)
          OP_LW, OP_SW: state_d = S_MEMADR;
          OP_REG:       state_d = S_REXEC;
          OP_ADDI:      state_d = S_IEXEC;
          OP_BEQ:       state_d = S_BRANCH;
          OP_JMP:       state_d = S_JUMP;
          default:      state_d = S_FETCH;
        endcase
      end
      S_MEMADR: state_d = (opcode == OP_LW) ? S_MEMRD : S_MEMWR;
      S_MEMRD:  state_d = S_LDWB;
      S_REXEC:  state_d = S_RWB;
      S_IEXEC:  state_d = S_IWB;
      default:  state_d = S_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_FETCH;
    else        state_q <= state_d;
  end

  // Moore outputs: a function of state_q alone
  always_comb begin
    ctl          = '0;
    ctl.pc_sel   = PCN_ALU;
    ctl.srcb     = SB_FOUR;
    ctl.alu_mode = MODE_ADD;
    case (state_q)
      S_FETCH: begin
        ctl.ir_we = 1'b1;
        ctl.pc_we = 1'b1;
      end
      S_DECODE: ctl.srcb = SB_BROFF;
      S_MEMADR, S_IEXEC: begin
        ctl.srca_reg = 1'b1;
        ctl.srcb     = SB_IMM;
      end
      S_MEMRD: begin
        ctl.addr_aluout = 1'b1;
        ctl.mdr_we      = 1'b1;
      end
      S_LDWB: begin
        ctl.rf_we  = 1'b1;
        ctl.wb_mdr = 1'b1;
        ctl.retire = 1'b1;
      end
      S_MEMWR: begin
        ctl.addr_aluout = 1'b1;
        ctl.mem_we      = 1'b1;
        ctl.retire      = 1'b1;
      end
      S_REXEC: begin
        ctl.srca_reg = 1'b1;
        ctl.srcb     = SB_REG;
        ctl.alu_mode = MODE_FUNCT;
      end
      S_RWB: begin
        ctl.rf_we  = 1'b1;
        ctl.dst_rd = 1'b1;
        ctl.retire = 1'b1;
      end
      S_IWB: begin
        ctl.rf_we  = 1'b1;
        ctl.retire = 1'b1;
      end
      S_BRANCH: begin
        ctl.srca_reg = 1'b1;
        ctl.srcb     = SB_REG;
        ctl.alu_mode = MODE_SUB;
        ctl.pc_cond  = 1'b1;
        ctl.pc_sel   = PCN_ALUOUT;
        ctl.retire   = 1'b1;
      end
      S_JUMP: begin
        ctl.pc_we  = 1'b1;
        ctl.pc_sel = PCN_JUMP;
        ctl.retire = 1'b1;
      end
      default: ;
    endcase
  end

  assign state = state_q;

  assert_fetch_then_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_FETCH) |=> (state_q == S_DECODE));

  assert_retire_then_fetch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.retire |=> (state_q == S_FETCH));

  assert_load_writeback_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_LDWB) |-> ($past(state_q) == S_MEMRD));

endmodule

// File: rtl/mc_core.sv
module mc_core import mc_pkg::*; #(
  parameter int          MEM_WORDS   = 256,
  parameter logic [31:0] RESET_PC    = 32'h0,
  parameter int          SYNC_STAGES = 2,
  localparam int         MAW         = $clog2(MEM_WORDS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_we,
  input  logic [MAW-1:0]  load_addr,
  input  logic [31:0]     load_data,
  input  logic [MAW-1:0]  peek_addr,
  output logic [31:0]     peek_data,
  output logic            retire,
  output logic [31:0]     pc
);

  logic            rst_core_n;
  state_t          state;
  ctrl_t           ctl;
  logic [XLEN-1:0] pc_q, ir_q, mdr_q, a_q, b_q, aluout_q;
  logic [XLEN-1:0] pc_nxt, mem_rdata, srca, srcb, alu_y, imm_sx, wb_data;
  logic [XLEN-1:0] rd1, rd2;
  logic            alu_zero, pc_load;
  logic [MAW-1:0]  mem_idx;
  logic [RAW-1:0]  wb_addr;
  alu_fn_t         alu_fn;
  logic [XLEN-1:0] mem [MEM_WORDS];

  mc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(rst_core_n)
  );

  mc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_core_n), .opcode(ir_q[31:26]),
    .state(state), .ctl(ctl)
  );

  mc_regfile #(.NREGS(32)) u_rf (
    .clk(clk), .rst_n(rst_core_n),
    .ra1(ir_q[25:21]), .ra2(ir_q[20:16]),
    .rd1(rd1), .rd2(rd2),
    .we(ctl.rf_we), .wa(wb_addr), .wd(wb_data)
  );

  // Operand selection for the single shared ALU
  assign imm_sx = {{16{ir_q[15]}}, ir_q[15:0]};
  assign srca   = ctl.srca_reg ? a_q : pc_q;

  always_comb begin
    case (ctl.srcb)
      SB_REG:   srcb = b_q;
      SB_IMM:   srcb = imm_sx;
      SB_BROFF: srcb = {imm_sx[XLEN-3:0], 2'b00};
      default:  srcb = 32'd4;
    endcase
  end

  assign alu_fn = alu_select(ctl.alu_mode, ir_q[5:0]);

  mc_alu u_alu (
    .opa(srca), .opb(srcb), .fn(alu_fn), .y(alu_y), .zero(alu_zero)
  );

  // Next PC
  always_comb begin
    case (ctl.pc_sel)
      PCN_ALUOUT: pc_nxt = aluout_q;
      PCN_JUMP:   pc_nxt = {pc_q[31:28], ir_q[25:0], 2'b00};
      default:    pc_nxt = alu_y;
    endcase
  end

  assign pc_load = ctl.pc_we | (ctl.pc_cond & alu_zero);

  // Write-back selection
  assign wb_addr = ctl.dst_rd ? ir_q[15:11] : ir_q[20:16];
  assign wb_data = ctl.wb_mdr ? mdr_q : aluout_q;

  // Unified memory: one address for fetch or data, one shared read path
  assign mem_idx   = ctl.addr_aluout ? aluout_q[MAW+1:2] : pc_q[MAW+1:2];
  assign mem_rdata = mem[mem_idx];
  assign peek_data = mem[peek_addr];

  always_ff @(posedge clk) begin
    if (load_we)         mem[load_addr] <= load_data;
    else if (ctl.mem_we) mem[aluout_q[MAW+1:2]] <= b_q;
  end

  // Architectural PC and internal holding registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  pc_q <= RESET_PC;
    else if (pc_load) pc_q <= pc_nxt;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)    ir_q <= '0;
    else if (ctl.ir_we) ir_q <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)     mdr_q <= '0;
    else if (ctl.mdr_we) mdr_q <= mem_rdata;
  end

  // Operand and result latches refresh on every cycle
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      a_q      <= '0;
      b_q      <= '0;
      aluout_q <= '0;
    end else begin
      a_q      <= rd1;
      b_q      <= rd2;
      aluout_q <= alu_y;
    end
  end

  assign retire = ctl.retire;
  assign pc     = pc_q;

  assert_pc_advance_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (state == S_FETCH) |=> (pc_q == $past(pc_q) + 32'd4));

  assert_ir_capture_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (state == S_FETCH) |=> (ir_q == $past(mem_rdata)));

  assert_beq_taken_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    (state == S_BRANCH && a_q == b_q) |=> (pc_q == $past(aluout_q)));

  assert_beq_not_taken_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    (state == S_BRANCH && a_q != b_q) |=> $stable(pc_q));

endmodule

// File: tb/mc_core_tb.sv
`timescale 1ns/1ps
module mc_core_tb;

  localparam int MW = 256;
  localparam int N_BODY = 60;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        load_we;
  logic [7:0]  load_addr;
  logic [31:0] load_data;
  logic [7:0]  peek_addr;
  logic [31:0] peek_data;
  logic        retire;
  logic [31:0] pc;

  always #2 clk = ~clk;

  mc_core #(.MEM_WORDS(MW)) u_dut (
    .clk(clk), .rst_n(rst_n), .load_we(load_we), .load_addr(load_addr),
    .load_data(load_data), .peek_addr(peek_addr), .peek_data(peek_data),
    .retire(retire), .pc(pc)
  );

  int vectors = 0;
  int miscompares = 0;

  logic [31:0] img   [MW];
  logic [31:0] m_mem [MW];
  logic [31:0] m_rf  [32];
  logic [31:0] m_pc;
  logic [31:0] halt_addr;
  int p;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(logic [5:0] fn, logic [4:0] rd, logic [4:0] rs, logic [4:0] rt);
    return {6'd0, rs, rt, rd, 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rt, logic [4:0] rs, logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] enc_j(int idx);
    return {6'd2, 26'(idx)};
  endfunction

  function automatic bit legal(logic [5:0] op);
    return op == 6'd0 || op == 6'd2 || op == 6'd4 || op == 6'd8 || op == 6'd35 || op == 6'd43;
  endfunction

  task automatic emit(input logic [31:0] w);
    img[p] = w;
    p++;
  endtask

  task automatic wr_reg(input logic [4:0] r, input logic [31:0] v);
    if (r != 5'd0) m_rf[r] = v;
  endtask

  // Reference model: one instruction per call, skipping illegal words first
  task automatic model_step(output int lat, output string tag);
    logic [31:0] ins, a, b, sx, pc4, ea, res;
    int skips;
    skips = 0;
    ins = m_mem[m_pc[9:2]];
    while (!legal(ins[31:26])) begin
      m_pc = m_pc + 4;
      skips++;
      ins = m_mem[m_pc[9:2]];
    end
    pc4 = m_pc + 4;
    a   = m_rf[ins[25:21]];
    b   = m_rf[ins[20:16]];
    sx  = {{16{ins[15]}}, ins[15:0]};
    ea  = a + sx;
    m_pc = pc4;
    lat = 4;
    tag = "R3";
    case (ins[31:26])
      6'd0: begin
        case (ins[5:0])
          6'd34:   res = a - b;
          6'd36:   res = a & b;
          6'd37:   res = a | b;
          6'd42:   res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          default: res = a + b;
        endcase
        wr_reg(ins[15:11], res);
      end
      6'd8:  begin wr_reg(ins[20:16], ea); tag = "R4"; end
      6'd35: begin wr_reg(ins[20:16], m_mem[ea[9:2]]); lat = 5; tag = "R5"; end
      6'd43: begin m_mem[ea[9:2]] = b; tag = "R6"; end
      6'd4: begin
        if (a == b) m_pc = pc4 + {sx[29:0], 2'b00};
        lat = 3; tag = "R7";
      end
      default: begin
        m_pc = {pc4[31:28], ins[25:0], 2'b00};
        lat = 3; tag = "R8";
      end
    endcase
    lat = lat + 2 * skips;
    if (skips > 0) tag = "R11";
  endtask

  function automatic logic [4:0] rnd_src();
    return 5'($urandom % 9);
  endfunction

  function automatic logic [4:0] rnd_dst();
    return 5'($urandom % 8);
  endfunction

  task automatic emit_mem(input logic [5:0] op, input logic [4:0] r);
    if ($urandom % 2 == 0)
      emit(enc_i(op, r, 5'd0, 16'(4 * (128 + ($urandom % 128)))));
    else
      emit(enc_i(op, r, 5'd8, 16'(4 * (int'($urandom % 128) - 72))));
  endtask

  task automatic build(input int variant);
    int loop_at, rem, off, k;
    logic [5:0] fns [5];
    logic [4:0] rs;
    fns[0] = 6'd32; fns[1] = 6'd34; fns[2] = 6'd36; fns[3] = 6'd37; fns[4] = 6'd42;
    p = 0;
    for (int w = 0; w < MW; w++) img[w] = (w < 128) ? 32'h0 : $urandom;
    if (variant == 0) begin
      emit(enc_i(6'd8, 5'd1, 5'd0, 16'hFFFB));            // r1 = -5
      emit(enc_i(6'd8, 5'd2, 5'd0, 16'd7));               // r2 = 7
      emit(enc_r(6'd42, 5'd3, 5'd1, 5'd2));               // signed slt -> 1
      emit(enc_r(6'd42, 5'd4, 5'd2, 5'd1));               // -> 0
      emit(enc_r(6'd34, 5'd5, 5'd1, 5'd2));               // -12
      emit(enc_i(6'd8, 5'd0, 5'd0, 16'd99));              // write to r0 dropped
      emit(enc_r(6'd32, 5'd6, 5'd0, 5'd2));
      emit(enc_i(6'd4, 5'd0, 5'd0, 16'd0));               // taken, offset 0
      emit(32'hFC00_0000);                                // illegal opcode 63
      emit(enc_i(6'd8, 5'd9, 5'd0, 16'd3));
      loop_at = p;
      emit(enc_i(6'd8, 5'd9, 5'd9, 16'hFFFF));
      emit(enc_i(6'd4, 5'd0, 5'd9, 16'd1));               // exits loop when zero
      emit(enc_j(loop_at));                               // backward jump
      emit(enc_i(6'd43, 5'd5, 5'd0, 16'(4 * 130)));
      emit(enc_i(6'd35, 5'd7, 5'd0, 16'(4 * 130)));       // load right after store
    end
    emit(enc_i(6'd8, 5'd8, 5'd0, 16'd800));
    for (int i = 0; i < N_BODY; i++) begin
      rem = N_BODY - 1 - i;
      k = $urandom % 16;
      off = $urandom % 3;
      if (off > rem) off = rem;
      if (k < 6)       emit(enc_r(fns[$urandom % 5], rnd_dst(), rnd_src(), rnd_src()));
      else if (k < 8)  emit(enc_i(6'd8, rnd_dst(), rnd_src(), 16'($urandom)));
      else if (k < 10) emit_mem(6'd43, rnd_src());
      else if (k < 12) emit_mem(6'd35, rnd_dst());
      else if (k < 14) begin
        rs = rnd_src();
        emit(enc_i(6'd4, ($urandom % 2 == 0) ? rs : rnd_src(), rs, 16'(off)));
      end
      else if (k == 14) emit(enc_j(p + 1 + off));
      else emit({6'(48 + ($urandom % 8)), 26'($urandom)});
    end
    for (int n = 0; n < 32; n++) emit(enc_i(6'd43, 5'(n), 5'd0, 16'(4 * (224 + n))));
    halt_addr = 32'(p * 4);
    emit(enc_j(p));
  endtask

  task automatic run_prog(input int variant);
    int cyc, guard, lat;
    bit pend, first, done;
    string tag;
    int probe [4];
    probe[0] = 0; probe[1] = 5; probe[2] = 130; probe[3] = 255;
    build(variant);
    rst_n = 1'b0;
    for (int w = 0; w < MW; w++) begin
      @(negedge clk);
      load_we = 1'b1; load_addr = 8'(w); load_data = img[w];
    end
    @(negedge clk);
    load_we = 1'b0;
    for (int w = 0; w < MW; w++) m_mem[w] = img[w];
    for (int r = 0; r < 32; r++) m_rf[r] = 32'h0;
    m_pc = 32'h0;
    for (int j = 0; j < 4; j++) begin
      peek_addr = 8'(probe[j]);
      #1;
      check(peek_data == img[probe[j]], "R12 fill/peek", peek_data, img[probe[j]]);
    end
    check(retire == 1'b0, "R1 retire in reset", 32'(retire), 32'h0);
    check(pc == 32'h0, "R1 pc in reset", pc, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cyc = 0; guard = 0; pend = 0; first = 1; done = 0;
    while (!done && guard < 20000) begin
      @(negedge clk);
      guard++;
      cyc++;
      if (first) begin
        check(pc == 32'h0 && retire == 1'b0, "R1 first fetch", pc, 32'h0);
        first = 0;
      end
      if (pend) begin
        check(pc == m_pc, {"R2 next pc after ", tag}, pc, m_pc);
        pend = 0;
        if (m_pc == halt_addr) done = 1;
      end
      if (retire && !done) begin
        model_step(lat, tag);
        check(cyc == lat, {"R10 latency of ", tag}, 32'(cyc), 32'(lat));
        cyc = 0;
        pend = 1;
      end
    end
    check(done, "R10 program reached halt", 32'(guard), 32'h0);
    for (int w = 128; w < MW; w++) begin
      peek_addr = 8'(w);
      #1;
      check(peek_data == m_mem[w], (w == 224) ? "R9 zero register stored" : "R6 data word",
            peek_data, m_mem[w]);
    end
  endtask

  initial begin
    #(4ns * 190000);
    miscompares++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    load_we = 1'b0;
    load_addr = '0;
    load_data = '0;
    peek_addr = '0;
    for (int v = 0; v < 3; v++) run_prog(v);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule